// File: doc/BRIEF.md
# In-Order Store Commit Buffer

This block holds stores between dispatch and their write into the level-one data cache. Dispatch claims an entry in program order before either operand is known. The entry's tag is returned to the execution side, which later fills in the store data and the store address. These two writes are independent and may arrive in either order or together. A store stays speculative (junior) until retirement promotes it to senior. A flush throws away every junior entry and never touches a senior one.

Only the oldest entry may write the cache, and only after it is senior, has both operands, and the cache reports that the core owns the line (Exclusive or Modified). If the line is missing or only Shared, the head sends an ownership request for the whole line to the fill-buffer side and stays at the head until a fill for that line arrives. An optional early mode also looks at the senior entry directly behind the head and requests its line ahead of time. The cache write itself still happens strictly in order.

Top module: `store_commit_buffer`

## Requirements
- R1: An allocation is accepted when `allocValid` and `allocReady` are both high. `allocIdx` names the claimed entry, and tags are handed out in increasing order modulo DEPTH, starting at 0 after reset.
- R2: The data write and the address write to an entry are accepted in either order or in the same cycle. An entry writes the cache only after it has both.
- R3: Each `retireValid` cycle promotes the oldest junior entry to senior. A retire pulse while no junior entry exists has no effect.
- R4: Cache writes occur strictly in allocation order. A junior entry never writes the cache.
- R5: The head writes the cache (`l1WrEn` high for one cycle) only while `l1LookupState` is 2 (Exclusive) or 3 (Modified). The write carries the entry's full address, its data and its byte mask, and the write leaves the line Modified in the cache.
- R6: A senior head with a known address whose line state is 0 (Invalid) or 1 (Shared) raises `rfoValid` with `rfoLine` equal to address bits above the line offset. It issues at most one accepted request per line until a fill for that line arrives, and it does not write the cache meanwhile.
- R7: `fillValid` with a matching `fillLine` ends the wait, after which the head commits as soon as the line is owned.
- R8: With EARLY_OWN set, when the head is not requesting, the senior entry right behind the head requests its own line if it is unowned, has not been requested yet, and differs from the head's line.
- R9: `flush` discards all junior entries, including one allocated in the same cycle. Senior entries survive and still commit.
- R10: `bufFull` is high exactly when DEPTH entries are held, and it then drops `allocReady`. `bufEmpty` is high exactly when none are held.
- R11: The byte mask is a run of 2^size ones (`addrSize` 0..3 gives 1, 2, 4 or 8 bytes) shifted left by the address bits below the word size. Bits shifted past the 8-byte word are dropped, so a store never leaves its line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Dispatch requests an entry |
| allocReady | output | 1 | An entry can be claimed |
| allocIdx | output | IDX_W | Tag of the entry claimed this cycle |
| dataValid | input | 1 | Store data write |
| dataIdx | input | IDX_W | Entry receiving the data |
| dataIn | input | 8*DATA_BYTES | Store data, byte lane aligned |
| addrValid | input | 1 | Store address write |
| addrIdx | input | IDX_W | Entry receiving the address |
| addrIn | input | ADDR_W | Physical store address |
| addrSize | input | 2 | log2 of store size in bytes |
| retireValid | input | 1 | Promote oldest junior entry |
| flush | input | 1 | Discard all junior entries |
| bufEmpty | output | 1 | No entry held |
| bufFull | output | 1 | All entries held |
| l1LookupLine | output | LINE_W | Line address of the head entry |
| l1LookupState | input | 2 | Cache state of that line: 0 I, 1 S, 2 E, 3 M |
| l1ProbeLine | output | LINE_W | Line address of the entry behind the head |
| l1ProbeState | input | 2 | Cache state of the probed line |
| l1WrEn | output | 1 | Head commits into the cache this cycle |
| l1WrAddr | output | ADDR_W | Address of the committing store |
| l1WrData | output | 8*DATA_BYTES | Data of the committing store |
| l1WrMask | output | DATA_BYTES | Byte mask of the committing store |
| rfoValid | output | 1 | Ownership request |
| rfoLine | output | LINE_W | Line being requested |
| rfoReady | input | 1 | Fill-buffer side accepts the request |
| fillValid | input | 1 | An ownership fill completed |
| fillLine | input | LINE_W | Line whose fill completed |

## Verification
The hardest state to reach is a head waiting on an ownership request while a second senior entry on another line sits behind it. Only then can the early request appear, and its order against the head's request be seen. The bench gets there by keeping both lines Invalid in its cache model, retiring the two stores in back-to-back cycles, and withholding fills until both requests are logged. A flush with a stalled senior head is built the same way: the head's line is held Invalid and requests are refused, so the senior entry is provably still present when the flush arrives.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    LINE_INV = 2'd0,
    LINE_SHR = 2'd1,
    LINE_EXC = 2'd2,
    LINE_MOD = 2'd3
  } lineState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic allocEn;
    logic headRfoSet;
    logic probeRfoSet;
  } sbStrobes_t;

  function automatic logic isOwned(input logic [1:0] st);
    return (st == LINE_EXC) || (st == LINE_MOD);
  endfunction

endpackage

// File: rtl/sb_datapath.sv
module sb_datapath
  import sb_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8,
  parameter int LINE_BYTES = 64,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int DATA_W    = 8 * DATA_BYTES,
  localparam int WOFF_W    = $clog2(DATA_BYTES),
  localparam int LOFF_W    = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - LOFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbStrobes_t        strb,
  input  logic [IDX_W-1:0]  allocIdx,
  input  logic [IDX_W-1:0]  headIdx,
  input  logic [IDX_W-1:0]  probeIdx,
  input  logic              dataValid,
  input  logic [IDX_W-1:0]  dataIdx,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              addrValid,
  input  logic [IDX_W-1:0]  addrIdx,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [1:0]        addrSize,
  input  logic              fillValid,
  input  logic [LINE_W-1:0] fillLine,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] headData,
  output logic [DATA_BYTES-1:0] headMask,
  output logic              headAddrOk,
  output logic              headDataOk,
  output logic              headRfoSent,
  output logic [ADDR_W-1:0] probeAddr,
  output logic              probeAddrOk,
  output logic              probeRfoSent
);

  logic [ADDR_W-1:0]     addrArr  [DEPTH];
  logic [DATA_W-1:0]     dataArr  [DEPTH];
  logic [DATA_BYTES-1:0] maskArr  [DEPTH];
  logic                  addrOkV  [DEPTH];
  logic                  dataOkV  [DEPTH];
  logic                  rfoSentV [DEPTH];

  function automatic logic [DATA_BYTES-1:0] byteMask(input logic [1:0] sz,
                                                     input logic [WOFF_W-1:0] off);
    logic [2*DATA_BYTES-1:0] run;
    run = (2*DATA_BYTES)'((1 << (1 << sz)) - 1);
    run = run << off;
    return run[DATA_BYTES-1:0];
  endfunction

  logic [DATA_BYTES-1:0] newMask;
  assign newMask = byteMask(addrSize, addrIn[WOFF_W-1:0]);

  for (genvar e = 0; e < DEPTH; e++) begin : gEntry
    logic [ADDR_W-1:0]     eAddr;
    logic [DATA_W-1:0]     eData;
    logic [DATA_BYTES-1:0] eMask;
    logic                  eAddrOk, eDataOk, eRfoSent;
    logic                  isAlloc, isHeadSet, isProbeSet, fillHit;

    assign isAlloc    = strb.allocEn && (allocIdx == IDX_W'(e));
    assign isHeadSet  = strb.headRfoSet && (headIdx == IDX_W'(e));
    assign isProbeSet = strb.probeRfoSet && (probeIdx == IDX_W'(e));
    assign fillHit    = fillValid && eAddrOk && (eAddr[ADDR_W-1:LOFF_W] == fillLine);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        eAddrOk  <= 1'b0;
        eDataOk  <= 1'b0;
        eRfoSent <= 1'b0;
      end else if (isAlloc) begin
        eAddrOk  <= 1'b0;
        eDataOk  <= 1'b0;
        eRfoSent <= 1'b0;
      end else begin
        if (addrValid && addrIdx == IDX_W'(e)) eAddrOk <= 1'b1;
        if (dataValid && dataIdx == IDX_W'(e)) eDataOk <= 1'b1;
        if (fillHit) eRfoSent <= 1'b0;
        if (isHeadSet || isProbeSet) eRfoSent <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (addrValid && addrIdx == IDX_W'(e)) begin
        eAddr <= addrIn;
        eMask <= newMask;
      end
      if (dataValid && dataIdx == IDX_W'(e)) eData <= dataIn;
    end

    assign addrArr[e]  = eAddr;
    assign dataArr[e]  = eData;
    assign maskArr[e]  = eMask;
    assign addrOkV[e]  = eAddrOk;
    assign dataOkV[e]  = eDataOk;
    assign rfoSentV[e] = eRfoSent;
  end

  assign headAddr     = addrArr[headIdx];
  assign headData     = dataArr[headIdx];
  assign headMask     = maskArr[headIdx];
  assign headAddrOk   = addrOkV[headIdx];
  assign headDataOk   = dataOkV[headIdx];
  assign headRfoSent  = rfoSentV[headIdx];
  assign probeAddr    = addrArr[probeIdx];
  assign probeAddrOk  = addrOkV[probeIdx];
  assign probeRfoSent = rfoSentV[probeIdx];

endmodule

// File: rtl/sb_control.sv
module sb_control
  import sb_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter bit EARLY_OWN = 1'b1,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int PTR_W    = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             retireValid,
  input  logic             flush,
  input  logic             headAddrOk,
  input  logic             headDataOk,
  input  logic             headRfoSent,
  input  logic             headOwned,
  input  logic             probeAddrOk,
  input  logic             probeRfoSent,
  input  logic             probeOwned,
  input  logic             probeSameLine,
  input  logic             rfoReady,
  output logic             allocReady,
  output logic             bufFull,
  output logic             bufEmpty,
  output logic [IDX_W-1:0] allocIdx,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] probeIdx,
  output sbStrobes_t       strb,
  output logic             commitFire,
  output logic             rfoValid,
  output logic             rfoFromProbe
);

  logic [PTR_W-1:0] headPtr, tailPtr, seniorCnt, usedCnt;
  logic [PTR_W-1:0] headNext, seniorNext;
  logic hasSenior, hasJunior, allocFire, retireFire, headRfo, probeRfo;

  assign usedCnt   = tailPtr - headPtr;
  assign bufFull   = (usedCnt == PTR_W'(DEPTH));
  assign bufEmpty  = (usedCnt == '0);
  assign hasSenior = (seniorCnt != '0);
  assign hasJunior = (usedCnt != seniorCnt);

  assign allocReady = !bufFull;
  assign allocFire  = allocValid && !bufFull;
  assign retireFire = retireValid && hasJunior;

  assign allocIdx = tailPtr[IDX_W-1:0];
  assign headIdx  = headPtr[IDX_W-1:0];
  assign probeIdx = headIdx + IDX_W'(1);

  assign commitFire = hasSenior && headAddrOk && headDataOk && headOwned;
  assign headRfo    = hasSenior && headAddrOk && !headOwned && !headRfoSent;

  if (EARLY_OWN) begin : gEarly
    assign probeRfo = (seniorCnt >= PTR_W'(2)) && probeAddrOk && !probeOwned
                      && !probeRfoSent && !probeSameLine && !headRfo;
  end else begin : gNoEarly
    assign probeRfo = 1'b0;
  end

  assign rfoValid     = headRfo || probeRfo;
  assign rfoFromProbe = !headRfo;

  assign strb.allocEn     = allocFire;
  assign strb.headRfoSet  = headRfo && rfoReady;
  assign strb.probeRfoSet = probeRfo && rfoReady;

  assign headNext   = headPtr + PTR_W'(commitFire);
  assign seniorNext = seniorCnt + PTR_W'(retireFire) - PTR_W'(commitFire);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      seniorCnt <= '0;
    end else begin
      headPtr   <= headNext;
      seniorCnt <= seniorNext;
      if (flush) tailPtr <= headNext + seniorNext;
      else       tailPtr <= tailPtr + PTR_W'(allocFire);
    end
  end

endmodule

// File: rtl/store_commit_buffer.sv
module store_commit_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8,
  parameter int LINE_BYTES = 64,
  parameter bit EARLY_OWN  = 1'b1,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int DATA_W    = 8 * DATA_BYTES,
  localparam int LOFF_W    = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - LOFF_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  allocValid,
  output logic                  allocReady,
  output logic [IDX_W-1:0]      allocIdx,
  input  logic                  dataValid,
  input  logic [IDX_W-1:0]      dataIdx,
  input  logic [DATA_W-1:0]     dataIn,
  input  logic                  addrValid,
  input  logic [IDX_W-1:0]      addrIdx,
  input  logic [ADDR_W-1:0]     addrIn,
  input  logic [1:0]            addrSize,
  input  logic                  retireValid,
  input  logic                  flush,
  output logic                  bufEmpty,
  output logic                  bufFull,
  output logic [LINE_W-1:0]     l1LookupLine,
  input  logic [1:0]            l1LookupState,
  output logic [LINE_W-1:0]     l1ProbeLine,
  input  logic [1:0]            l1ProbeState,
  output logic                  l1WrEn,
  output logic [ADDR_W-1:0]     l1WrAddr,
  output logic [DATA_W-1:0]     l1WrData,
  output logic [DATA_BYTES-1:0] l1WrMask,
  output logic                  rfoValid,
  output logic [LINE_W-1:0]     rfoLine,
  input  logic                  rfoReady,
  input  logic                  fillValid,
  input  logic [LINE_W-1:0]     fillLine
);

  sbStrobes_t strb;
  logic [IDX_W-1:0] headIdx, probeIdx;
  logic [ADDR_W-1:0] headAddr, probeAddr;
  logic headAddrOk, headDataOk, headRfoSent, probeAddrOk, probeRfoSent;
  logic rfoFromProbe;

  assign l1LookupLine = headAddr[ADDR_W-1:LOFF_W];
  assign l1ProbeLine  = probeAddr[ADDR_W-1:LOFF_W];
  assign l1WrAddr     = headAddr;
  assign rfoLine      = rfoFromProbe ? l1ProbeLine : l1LookupLine;

  sb_control #(.DEPTH(DEPTH), .EARLY_OWN(EARLY_OWN)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .retireValid(retireValid), .flush(flush),
    .headAddrOk(headAddrOk), .headDataOk(headDataOk), .headRfoSent(headRfoSent),
    .headOwned(isOwned(l1LookupState)),
    .probeAddrOk(probeAddrOk), .probeRfoSent(probeRfoSent),
    .probeOwned(isOwned(l1ProbeState)),
    .probeSameLine(l1ProbeLine == l1LookupLine),
    .rfoReady(rfoReady),
    .allocReady(allocReady), .bufFull(bufFull), .bufEmpty(bufEmpty),
    .allocIdx(allocIdx), .headIdx(headIdx), .probeIdx(probeIdx),
    .strb(strb), .commitFire(l1WrEn), .rfoValid(rfoValid),
    .rfoFromProbe(rfoFromProbe)
  );

  sb_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES),
                .LINE_BYTES(LINE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .allocIdx(allocIdx), .headIdx(headIdx), .probeIdx(probeIdx),
    .dataValid(dataValid), .dataIdx(dataIdx), .dataIn(dataIn),
    .addrValid(addrValid), .addrIdx(addrIdx), .addrIn(addrIn), .addrSize(addrSize),
    .fillValid(fillValid), .fillLine(fillLine),
    .headAddr(headAddr), .headData(l1WrData), .headMask(l1WrMask),
    .headAddrOk(headAddrOk), .headDataOk(headDataOk), .headRfoSent(headRfoSent),
    .probeAddr(probeAddr), .probeAddrOk(probeAddrOk), .probeRfoSent(probeRfoSent)
  );

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int LINE_W     = 26,
  parameter int DATA_BYTES = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  allocValid,
  input logic                  flush,
  input logic                  bufEmpty,
  input logic                  bufFull,
  input logic [1:0]            l1LookupState,
  input logic [LINE_W-1:0]     l1LookupLine,
  input logic                  l1WrEn,
  input logic [DATA_BYTES-1:0] l1WrMask,
  input logic                  rfoValid,
  input logic [LINE_W-1:0]     rfoLine
);

  a_r10_full_empty_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(bufFull && bufEmpty));

  a_r10_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !l1WrEn && !flush) |=> bufFull);

  a_r1_empty_holds: assert property (@(posedge clk) disable iff (!rstN)
    (bufEmpty && !allocValid) |=> bufEmpty);

  a_r5_commit_owned: assert property (@(posedge clk) disable iff (!rstN)
    l1WrEn |-> l1LookupState[1]);

  a_r4_commit_not_empty: assert property (@(posedge clk) disable iff (!rstN)
    l1WrEn |-> !bufEmpty);

  a_r6_no_rfo_for_committing_line: assert property (@(posedge clk) disable iff (!rstN)
    l1WrEn |-> !(rfoValid && rfoLine == l1LookupLine));

  a_r11_mask_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    l1WrEn |-> (l1WrMask != '0));

endmodule

bind store_commit_buffer sb_checker #(.LINE_W(LINE_W), .DATA_BYTES(DATA_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .allocValid(allocValid), .flush(flush),
  .bufEmpty(bufEmpty), .bufFull(bufFull), .l1LookupState(l1LookupState),
  .l1LookupLine(l1LookupLine), .l1WrEn(l1WrEn), .l1WrMask(l1WrMask),
  .rfoValid(rfoValid), .rfoLine(rfoLine)
);

// File: tb/tb_store_commit_buffer.sv
module tb_store_commit_buffer;

  localparam int DEPTH = 8;
  localparam int IDX_W = 3;
  localparam int ADDR_W = 32;
  localparam int LINE_W = 26;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 0, dataValid = 0, addrValid = 0, retireValid = 0, flush = 0;
  logic [IDX_W-1:0] dataIdx = '0, addrIdx = '0;
  logic [63:0] dataIn = '0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [1:0] addrSize = '0;
  logic rfoReady = 1'b1, fillValid = 1'b0;
  logic [LINE_W-1:0] fillLine = '0;
  logic allocReady, bufEmpty, bufFull, l1WrEn, rfoValid;
  logic [IDX_W-1:0] allocIdx;
  logic [LINE_W-1:0] l1LookupLine, l1ProbeLine, rfoLine;
  logic [1:0] l1LookupState, l1ProbeState;
  logic [ADDR_W-1:0] l1WrAddr;
  logic [63:0] l1WrData;
  logic [7:0] l1WrMask;

  logic [1:0] lineSt [16];
  int checks = 0, errors = 0;
  int commitCnt = 0, rfoCnt = 0;
  logic [ADDR_W-1:0] cAddr [64];
  logic [63:0] cData [64];
  logic [7:0] cMask [64];
  logic [LINE_W-1:0] rLine [64];
  int nextIdx = 0;

  always #4 clk = ~clk;

  assign l1LookupState = lineSt[l1LookupLine[3:0]];
  assign l1ProbeState  = lineSt[l1ProbeLine[3:0]];

  store_commit_buffer dut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocReady(allocReady),
    .allocIdx(allocIdx), .dataValid(dataValid), .dataIdx(dataIdx), .dataIn(dataIn),
    .addrValid(addrValid), .addrIdx(addrIdx), .addrIn(addrIn), .addrSize(addrSize),
    .retireValid(retireValid), .flush(flush), .bufEmpty(bufEmpty), .bufFull(bufFull),
    .l1LookupLine(l1LookupLine), .l1LookupState(l1LookupState),
    .l1ProbeLine(l1ProbeLine), .l1ProbeState(l1ProbeState),
    .l1WrEn(l1WrEn), .l1WrAddr(l1WrAddr), .l1WrData(l1WrData), .l1WrMask(l1WrMask),
    .rfoValid(rfoValid), .rfoLine(rfoLine), .rfoReady(rfoReady),
    .fillValid(fillValid), .fillLine(fillLine)
  );

  always @(negedge clk) begin
    if (rstN && l1WrEn) begin
      cAddr[commitCnt % 64] = l1WrAddr;
      cData[commitCnt % 64] = l1WrData;
      cMask[commitCnt % 64] = l1WrMask;
      commitCnt = commitCnt + 1;
    end
    if (rstN && rfoValid && rfoReady) begin
      rLine[rfoCnt % 64] = rfoLine;
      rfoCnt = rfoCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic allocOne(output logic [IDX_W-1:0] idx);
    allocValid = 1'b1;
    idx = allocIdx;
    check(allocIdx == IDX_W'(nextIdx), "R1 alloc tag", allocIdx, nextIdx);
    nextIdx = (nextIdx + 1) % DEPTH;
    tick();
    allocValid = 1'b0;
  endtask

  task automatic putAddr(input logic [IDX_W-1:0] idx, input logic [ADDR_W-1:0] a,
                         input logic [1:0] sz);
    addrValid = 1'b1; addrIdx = idx; addrIn = a; addrSize = sz;
    tick();
    addrValid = 1'b0;
  endtask

  task automatic putData(input logic [IDX_W-1:0] idx, input logic [63:0] d);
    dataValid = 1'b1; dataIdx = idx; dataIn = d;
    tick();
    dataValid = 1'b0;
  endtask

  task automatic putBoth(input logic [IDX_W-1:0] idx, input logic [ADDR_W-1:0] a,
                         input logic [1:0] sz, input logic [63:0] d);
    addrValid = 1'b1; addrIdx = idx; addrIn = a; addrSize = sz;
    dataValid = 1'b1; dataIdx = idx; dataIn = d;
    tick();
    addrValid = 1'b0; dataValid = 1'b0;
  endtask

  task automatic retireOne();
    retireValid = 1'b1;
    tick();
    retireValid = 1'b0;
  endtask

  task automatic flushOne(input int juniors);
    flush = 1'b1;
    tick();
    flush = 1'b0;
    nextIdx = (nextIdx - juniors + DEPTH) % DEPTH;
  endtask

  // {size, offset, expected mask}  (R11)
  localparam logic [12:0] VEC [8] = '{
    {2'd0, 3'd3, 8'h08}, {2'd1, 3'd6, 8'hC0}, {2'd2, 3'd4, 8'hF0},
    {2'd3, 3'd0, 8'hFF}, {2'd2, 3'd6, 8'hC0}, {2'd1, 3'd7, 8'h80},
    {2'd3, 3'd1, 8'hFE}, {2'd0, 3'd0, 8'h01}
  };

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [IDX_W-1:0] ia, ib, ic;
    int base, rbase;
    for (int i = 0; i < 16; i++) lineSt[i] = 2'd3;
    tick(3);
    rstN = 1'b1;
    tick();

    // reset state
    check(bufEmpty && !bufFull && allocReady, "R10 reset flags", {bufEmpty, bufFull}, 2'b10);
    check(!l1WrEn && !rfoValid, "R5 reset idle", {l1WrEn, rfoValid}, 0);

    // table walk: masks, data, write order variants
    for (int i = 0; i < 8; i++) begin
      logic [ADDR_W-1:0] a;
      logic [63:0] d;
      a = 32'h40 + ADDR_W'(VEC[i][10:8]);
      d = 64'h1122_3344_0000_0000 + 64'(i);
      base = commitCnt;
      allocOne(ia);
      if (i == 7) putBoth(ia, a, VEC[i][12:11], d);
      else if (i % 2 == 0) begin putData(ia, d); putAddr(ia, a, VEC[i][12:11]); end
      else begin putAddr(ia, a, VEC[i][12:11]); putData(ia, d); end
      retireOne();
      tick(2);
      check(commitCnt == base + 1, "R2 commit after both writes", commitCnt, base + 1);
      check(cMask[base % 64] == VEC[i][7:0], "R11 byte mask", cMask[base % 64], VEC[i][7:0]);
      check(cData[base % 64] == d && cAddr[base % 64] == a, "R5 write data/addr",
            cData[base % 64], d);
    end
    check(bufEmpty, "R10 empty after drain", bufEmpty, 1);

    // junior store never commits; retire with no junior is ignored
    retireOne();
    base = commitCnt;
    allocOne(ia);
    putBoth(ia, 32'h80, 2'd3, 64'hAA);
    tick(5);
    check(commitCnt == base, "R3 stale retire ignored / R4 junior held", commitCnt, base);
    retireOne();
    tick(2);
    check(commitCnt == base + 1, "R3 retire promotes", commitCnt, base + 1);

    // order: operands written in reverse allocation order
    base = commitCnt;
    allocOne(ia); allocOne(ib); allocOne(ic);
    putBoth(ic, 32'h0C0, 2'd3, 64'hC);
    putAddr(ib, 32'h100, 2'd3); putData(ib, 64'hB);
    putData(ia, 64'hA); putAddr(ia, 32'h140, 2'd3);
    retireOne(); retireOne(); retireOne();
    tick(3);
    check(commitCnt == base + 3, "R4 three commits", commitCnt, base + 3);
    check(cAddr[base % 64] == 32'h140 && cAddr[(base + 1) % 64] == 32'h100
          && cAddr[(base + 2) % 64] == 32'h0C0, "R4 program order",
          cAddr[base % 64], 32'h140);

    // full buffer
    for (int k = 0; k < DEPTH; k++) allocOne(ia);
    check(bufFull && !allocReady && !bufEmpty, "R10 full flags", {bufFull, allocReady}, 2'b10);
    allocValid = 1'b1; tick(); allocValid = 1'b0;
    check(bufFull, "R10 alloc refused when full", bufFull, 1);
    flushOne(DEPTH);
    check(bufEmpty && !bufFull, "R9 flush drops all juniors", {bufEmpty, bufFull}, 2'b10);

    // flush keeps a stalled senior head
    lineSt[6] = 2'd0;
    rfoReady = 1'b0;
    base = commitCnt;
    allocOne(ia); putBoth(ia, 32'h180, 2'd3, 64'h61);
    allocOne(ib); putBoth(ib, 32'h188, 2'd3, 64'h62);
    allocOne(ic); putBoth(ic, 32'h190, 2'd3, 64'h63);
    retireOne();
    tick(2);
    check(commitCnt == base && rfoValid && rfoLine == 26'd6, "R6 stalled head requests",
          rfoLine, 6);
    flushOne(2);
    check(!bufEmpty, "R9 senior survives flush", bufEmpty, 0);
    retireOne(); retireOne();
    lineSt[6] = 2'd3;
    rfoReady = 1'b1;
    tick(4);
    check(commitCnt == base + 1 && cData[base % 64] == 64'h61, "R9 only senior commits",
          commitCnt, base + 1);
    check(bufEmpty, "R9 empty after senior commit", bufEmpty, 1);

    // shared line: one ownership request, wait for fill
    lineSt[3] = 2'd1;
    base = commitCnt; rbase = rfoCnt;
    allocOne(ia); putBoth(ia, 32'h0C8, 2'd2, 64'h33);
    retireOne();
    check(rfoValid && rfoLine == 26'd3, "R6 request on shared line", rfoLine, 3);
    tick(4);
    check(rfoCnt == rbase + 1 && commitCnt == base, "R6 single request, no commit",
          rfoCnt, rbase + 1);
    lineSt[3] = 2'd2;
    fillValid = 1'b1; fillLine = 26'd3;
    tick();
    fillValid = 1'b0;
    tick(2);
    check(commitCnt == base + 1, "R7 commit after fill", commitCnt, base + 1);

    // early ownership for the entry behind the head
    lineSt[4] = 2'd0; lineSt[5] = 2'd0;
    base = commitCnt; rbase = rfoCnt;
    allocOne(ia); putBoth(ia, 32'h100, 2'd3, 64'h44);
    allocOne(ib); putBoth(ib, 32'h140, 2'd3, 64'h55);
    retireOne(); retireOne();
    tick(3);
    check(rfoCnt == rbase + 2, "R8 two requests", rfoCnt, rbase + 2);
    check(rLine[rbase % 64] == 26'd4 && rLine[(rbase + 1) % 64] == 26'd5,
          "R8 head first then follower", rLine[(rbase + 1) % 64], 5);
    check(commitCnt == base, "R8 no commit before fills", commitCnt, base);
    lineSt[4] = 2'd3; lineSt[5] = 2'd3;
    fillValid = 1'b1; fillLine = 26'd4; tick();
    fillLine = 26'd5; tick();
    fillValid = 1'b0;
    tick(3);
    check(commitCnt == base + 2 && cData[base % 64] == 64'h44
          && cData[(base + 1) % 64] == 64'h55, "R8 visible commit in order",
          cData[base % 64], 64'h44);
    check(bufEmpty, "R10 empty at end", bufEmpty, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule